// File: doc/BRIEF.md
# GPIO Bank with Edge Interrupts

A bank of general-purpose pins controlled through a plain register bus with a word address, write enable, write data and combinational read data. Each pin can drive an output value under its own output enable. Set and clear aliases let software change single pins without a read-modify-write. Every pin input passes through a two-flop synchronizer. It can then go through an optional debounce filter, and all filtered pins share one programmable tick divider.

Each pin can latch rising edges, falling edges or both into separate pending registers, each under its own enable bit. A combined view ORs the two pending bits of each pin. It is acknowledged by writing back the value that was read, and any pending bit drives the single interrupt output. Pull enable and pull direction bits are decoded into pull-up and pull-down control outputs for the pad ring.

Top module: `gpio_edge_bank`

## Requirements
- R1: After reset every register reads 0, padOe, pullUpEn, pullDnEn and irqOut are 0, and padOut is 0.
- R2: Word 4 (byte 0x10) writes the output value directly. Word 5 (0x14) sets only the 1 bits of the written mask. Word 6 (0x18) clears only the 1 bits. padOut shows the result on the clock after the write, and reading word 4 returns it.
- R3: Word 1 (0x04) writes the output enable directly. Word 7 (0x1C) sets only the 1 bits of the mask and word 8 (0x20) clears only the 1 bits. padOe shows the result on the clock after the write.
- R4: Reading word 0 (0x00) returns padIn delayed through two flops. A change is not visible after one clock and is visible after two.
- R5: A 0-to-1 change of a pin's filtered input sets its bit in the rising pending register (word 12, 0x30) only while bit n of the rising enable (word 10, 0x28) is 1. A 1-to-0 change sets its bit in the falling pending register (word 13, 0x34) only while bit n of the falling enable (word 11, 0x2C) is 1.
- R6: Word 3 (0x0C) reads as rising pending OR falling pending. Writing 1 to a bit clears both underlying bits, and 0 bits have no effect. irqOut is 1 exactly when any combined bit is 1.
- R7: Writing 1 to a bit of word 12 clears only that rising pending bit, and writing 1 to a bit of word 13 clears only that falling pending bit.
- R8: When a recorded edge and an acknowledge of the same pin land on the same clock, the pending bit for that edge ends up set.
- R9: The divider field is bits 29:16 of word 18 (0x48). All other bits of that word read 0.
- R10: For a pin whose bit in word 9 (0x24) is 1, the filtered input takes a new value only when the synchronized input held that value at two successive divider ticks, one tick every divider+1 clocks. A one-clock glitch is therefore dropped. A pin whose bit is 0 uses the synchronized input directly.
- R11: pullUpEn[n] = pullEnable[n] & pullSense[n] and pullDnEn[n] = pullEnable[n] & ~pullSense[n]. Pull enable is word 20 (0x50) and pull sense is word 21 (0x54).
- R12: The debounce, rising-enable, falling-enable, pull-enable and pull-sense words read back the value last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Word address (byte offset / 4) |
| busWe | input | 1 | Write strobe |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |
| padIn | input | PIN_COUNT | Pin input levels |
| padOut | output | PIN_COUNT | Output values |
| padOe | output | PIN_COUNT | Output enables |
| pullUpEn | output | PIN_COUNT | Pull-up control |
| pullDnEn | output | PIN_COUNT | Pull-down control |
| irqOut | output | 1 | Interrupt request |

## Verification
The assertions assume that busWe lasts a single clock for each access. They also assume that write data is stable around the sampling edge, so that each write produces at most one strobe and the value seen one clock later reflects only that write. The bench drives every bus input at the falling clock edge and holds a write for exactly one cycle. It changes padIn only at falling edges, and it times the same-cycle acknowledge case by counting the synchronizer flops. During the glitch test it keeps the debounce divider small enough that a one-clock pulse cannot span two ticks.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int DATA_W = 32;

  localparam int W_INPUT     = 0;
  localparam int W_OE        = 1;
  localparam int W_PEND      = 3;
  localparam int W_OUT       = 4;
  localparam int W_OUT_SET   = 5;
  localparam int W_OUT_CLR   = 6;
  localparam int W_OE_SET    = 7;
  localparam int W_OE_CLR    = 8;
  localparam int W_DEB_EN    = 9;
  localparam int W_RISE_EN   = 10;
  localparam int W_FALL_EN   = 11;
  localparam int W_RISE_PEND = 12;
  localparam int W_FALL_PEND = 13;
  localparam int W_DIV       = 18;
  localparam int W_PULL_EN   = 20;
  localparam int W_PULL_DIR  = 21;

  typedef struct packed {
    logic wrOe;
    logic setOe;
    logic clrOe;
    logic wrOut;
    logic setOut;
    logic clrOut;
    logic wrDeb;
    logic wrRiseEn;
    logic wrFallEn;
    logic ackRise;
    logic ackFall;
    logic ackBoth;
    logic wrDiv;
    logic wrPullEn;
    logic wrPullDir;
  } busStrobe_t;

  typedef enum logic [3:0] {
    RD_NONE, RD_INPUT, RD_OE, RD_PEND, RD_OUT, RD_DEB, RD_RISE_EN,
    RD_FALL_EN, RD_RISE_PEND, RD_FALL_PEND, RD_DIV, RD_PULL_EN, RD_PULL_DIR
  } readSel_t;
endpackage

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output busStrobe_t        strobe,
  output readSel_t          readSel
);
  always_comb begin
    strobe  = '0;
    readSel = RD_NONE;
    case (int'(busAddr))
      W_INPUT:     readSel = RD_INPUT;
      W_OE:        begin readSel = RD_OE;        strobe.wrOe      = busWe; end
      W_PEND:      begin readSel = RD_PEND;      strobe.ackBoth   = busWe; end
      W_OUT:       begin readSel = RD_OUT;       strobe.wrOut     = busWe; end
      W_OUT_SET:   strobe.setOut = busWe;
      W_OUT_CLR:   strobe.clrOut = busWe;
      W_OE_SET:    strobe.setOe  = busWe;
      W_OE_CLR:    strobe.clrOe  = busWe;
      W_DEB_EN:    begin readSel = RD_DEB;       strobe.wrDeb     = busWe; end
      W_RISE_EN:   begin readSel = RD_RISE_EN;   strobe.wrRiseEn  = busWe; end
      W_FALL_EN:   begin readSel = RD_FALL_EN;   strobe.wrFallEn  = busWe; end
      W_RISE_PEND: begin readSel = RD_RISE_PEND; strobe.ackRise   = busWe; end
      W_FALL_PEND: begin readSel = RD_FALL_PEND; strobe.ackFall   = busWe; end
      W_DIV:       begin readSel = RD_DIV;       strobe.wrDiv     = busWe; end
      W_PULL_EN:   begin readSel = RD_PULL_EN;   strobe.wrPullEn  = busWe; end
      W_PULL_DIR:  begin readSel = RD_PULL_DIR;  strobe.wrPullDir = busWe; end
      default: ;
    endcase
  end

  // R2 R3: a single bus write never fires two register updates
  a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe));
  // R6: a read leaves every register, including pending, untouched
  a_r6_read_no_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !busWe |-> (strobe == '0));
endmodule

// File: rtl/gpio_bank_datapath.sv
module gpio_bank_datapath
  import gpio_bank_pkg::*;
#(
  parameter int PIN_COUNT = 32,
  parameter int DIV_W     = 14,
  parameter int DIV_LSB   = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  busStrobe_t           strobe,
  input  readSel_t             readSel,
  input  logic [DATA_W-1:0]    busWdata,
  output logic [DATA_W-1:0]    busRdata,
  input  logic [PIN_COUNT-1:0] padIn,
  output logic [PIN_COUNT-1:0] padOut,
  output logic [PIN_COUNT-1:0] padOe,
  output logic [PIN_COUNT-1:0] pullUpEn,
  output logic [PIN_COUNT-1:0] pullDnEn,
  output logic                 irqOut
);
  localparam int PW = PIN_COUNT;

  logic [PW-1:0] wd;
  logic [PW-1:0] syncA, syncB, candReg, debReg, prevFilt, filt;
  logic [PW-1:0] outReg, oeReg, debEn, riseEn, fallEn, pullEn, pullDir;
  logic [PW-1:0] risePend, fallPend, riseEdge, fallEdge, newEdges;
  logic [PW-1:0] riseAck, fallAck;
  logic [DIV_W-1:0] divVal, divCnt;
  logic tick;

  assign wd       = busWdata[PW-1:0];
  assign tick     = (divCnt >= divVal);
  assign filt     = (debEn & debReg) | (~debEn & syncB);
  assign riseEdge = filt & ~prevFilt;
  assign fallEdge = ~filt & prevFilt;
  assign newEdges = (riseEdge & riseEn) | (fallEdge & fallEn);
  assign riseAck  = (strobe.ackBoth || strobe.ackRise) ? wd : '0;
  assign fallAck  = (strobe.ackBoth || strobe.ackFall) ? wd : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA <= '0; syncB <= '0; candReg <= '0; debReg <= '0; prevFilt <= '0;
      outReg <= '0; oeReg <= '0; debEn <= '0; riseEn <= '0; fallEn <= '0;
      pullEn <= '0; pullDir <= '0; risePend <= '0; fallPend <= '0;
      divVal <= '0; divCnt <= '0;
    end else begin
      syncA    <= padIn;
      syncB    <= syncA;
      prevFilt <= filt;
      if (strobe.wrOut)       outReg <= wd;
      else if (strobe.setOut) outReg <= outReg | wd;
      else if (strobe.clrOut) outReg <= outReg & ~wd;
      if (strobe.wrOe)        oeReg <= wd;
      else if (strobe.setOe)  oeReg <= oeReg | wd;
      else if (strobe.clrOe)  oeReg <= oeReg & ~wd;
      if (strobe.wrDeb)     debEn   <= wd;
      if (strobe.wrRiseEn)  riseEn  <= wd;
      if (strobe.wrFallEn)  fallEn  <= wd;
      if (strobe.wrPullEn)  pullEn  <= wd;
      if (strobe.wrPullDir) pullDir <= wd;
      if (strobe.wrDiv)     divVal  <= busWdata[DIV_LSB +: DIV_W];
      divCnt <= tick ? '0 : divCnt + 1'b1;
      if (tick) begin
        candReg <= syncB;
        debReg  <= (debReg & ~(syncB ~^ candReg)) | (syncB & (syncB ~^ candReg));
      end
      risePend <= (risePend & ~riseAck) | (riseEdge & riseEn);
      fallPend <= (fallPend & ~fallAck) | (fallEdge & fallEn);
    end
  end

  assign padOut   = outReg;
  assign padOe    = oeReg;
  assign pullUpEn = pullEn & pullDir;
  assign pullDnEn = pullEn & ~pullDir;
  assign irqOut   = |(risePend | fallPend);

  always_comb begin
    case (readSel)
      RD_INPUT:     busRdata = DATA_W'(syncB);
      RD_OE:        busRdata = DATA_W'(oeReg);
      RD_PEND:      busRdata = DATA_W'(risePend | fallPend);
      RD_OUT:       busRdata = DATA_W'(outReg);
      RD_DEB:       busRdata = DATA_W'(debEn);
      RD_RISE_EN:   busRdata = DATA_W'(riseEn);
      RD_FALL_EN:   busRdata = DATA_W'(fallEn);
      RD_RISE_PEND: busRdata = DATA_W'(risePend);
      RD_FALL_PEND: busRdata = DATA_W'(fallPend);
      RD_DIV:       busRdata = DATA_W'(divVal) << DIV_LSB;
      RD_PULL_EN:   busRdata = DATA_W'(pullEn);
      RD_PULL_DIR:  busRdata = DATA_W'(pullDir);
      default:      busRdata = '0;
    endcase
  end

  // R2: every bit named by a set-alias write is 1 on the next cycle
  a_r2_set_out: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setOut |=> ((padOut & $past(wd)) == $past(wd)));
  // R3: every bit named by a clear-alias write is 0 on the next cycle
  a_r3_clr_oe: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrOe |=> ((padOe & $past(wd)) == '0));
  // R5: a rising pending bit only appears while its enable was set
  a_r5_rise_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    ((risePend & ~$past(risePend) & ~$past(riseEn)) == '0));
  // R5: same for falling pending bits
  a_r5_fall_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    ((fallPend & ~$past(fallPend) & ~$past(fallEn)) == '0));
  // R6 R8: an acknowledged bit stays set only if a new enabled edge arrived
  a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ackBoth |=> (((risePend | fallPend) & $past(wd) & ~$past(newEdges)) == '0));
  // R10: the debounced value moves only on a divider tick
  a_r10_deb_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> $stable(debReg));
endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
  import gpio_bank_pkg::*;
#(
  parameter int PIN_COUNT = 32,
  parameter int ADDR_W    = 5,
  parameter int DIV_W     = 14,
  parameter int DIV_LSB   = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busWe,
  input  logic [31:0]          busWdata,
  output logic [31:0]          busRdata,
  input  logic [PIN_COUNT-1:0] padIn,
  output logic [PIN_COUNT-1:0] padOut,
  output logic [PIN_COUNT-1:0] padOe,
  output logic [PIN_COUNT-1:0] pullUpEn,
  output logic [PIN_COUNT-1:0] pullDnEn,
  output logic                 irqOut
);
  busStrobe_t strobe;
  readSel_t   readSel;

  gpio_bank_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .strobe(strobe), .readSel(readSel)
  );

  gpio_bank_datapath #(.PIN_COUNT(PIN_COUNT), .DIV_W(DIV_W), .DIV_LSB(DIV_LSB)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .readSel(readSel),
    .busWdata(busWdata), .busRdata(busRdata), .padIn(padIn),
    .padOut(padOut), .padOe(padOe), .pullUpEn(pullUpEn),
    .pullDnEn(pullDnEn), .irqOut(irqOut)
  );
endmodule

// File: tb/tb_gpio_edge_bank.sv
`timescale 1ns/1ps
module tb_gpio_edge_bank;
  logic clk = 1'b0;
  logic rstN;
  logic [4:0] busAddr;
  logic busWe;
  logic [31:0] busWdata, busRdata;
  logic [31:0] padIn, padOut, padOe, pullUpEn, pullDnEn;
  logic irqOut;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  logic [31:0] mOut, mOe, mRiseEn, mFallEn, mRiseP, mFallP, mPad;

  gpio_edge_bank dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .padIn(padIn),
    .padOut(padOut), .padOe(padOe), .pullUpEn(pullUpEn),
    .pullDnEn(pullDnEn), .irqOut(irqOut)
  );

  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input int idx, input logic [31:0] data);
    @(negedge clk);
    busAddr = 5'(idx); busWdata = data; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic busRead(input int idx, output logic [31:0] v);
    @(negedge clk);
    busAddr = 5'(idx); busWe = 1'b0;
    #1 v = busRdata;
  endtask

  function automatic logic [31:0] applyOp(input logic [31:0] cur, input int op, input logic [31:0] m);
    case (op)
      0: return m;
      1: return cur | m;
      default: return cur & ~m;
    endcase
  endfunction

  task automatic checkPending(input string req);
    logic [31:0] v;
    busRead(12, v); check({req, " rise pending"}, v, mRiseP);
    busRead(13, v); check({req, " fall pending"}, v, mFallP);
    busRead(3, v);  check({req, " combined"}, v, mRiseP | mFallP);
    check({req, " irq"}, {31'b0, irqOut}, {31'b0, |(mRiseP | mFallP)});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'h5eed_0042));
    rstN = 1'b0; busAddr = '0; busWe = 1'b0; busWdata = '0; padIn = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    check("R1 padOe", padOe, 0);
    check("R1 padOut", padOut, 0);
    check("R1 irqOut", {31'b0, irqOut}, 0);
    check("R1 pulls", pullUpEn | pullDnEn, 0);
    foreach (v[i]) begin end
    for (int w = 0; w < 22; w++) begin
      busRead(w, v); check("R1 register zero", v, 0);
    end

    // R12 enable register readback
    begin
      int idxs[5] = '{9, 10, 11, 20, 21};
      foreach (idxs[k]) begin
        logic [31:0] d = $urandom;
        busWrite(idxs[k], d); busRead(idxs[k], v); check("R12 readback", v, d);
        busWrite(idxs[k], 0);
      end
    end

    // R2 R3 random output value / enable ops
    mOut = 0; mOe = 0;
    for (int it = 0; it < 60; it++) begin
      int op = $urandom_range(0, 2);
      logic [31:0] m = $urandom;
      if ($urandom_range(0, 1) == 0) begin
        busWrite(op == 0 ? 4 : (op == 1 ? 5 : 6), m);
        mOut = applyOp(mOut, op, m);
        check("R2 padOut", padOut, mOut);
      end else begin
        busWrite(op == 0 ? 1 : (op == 1 ? 7 : 8), m);
        mOe = applyOp(mOe, op, m);
        check("R3 padOe", padOe, mOe);
      end
    end
    busRead(4, v); check("R2 out readback", v, mOut);
    busRead(1, v); check("R3 oe readback", v, mOe);

    // R4 input latency
    @(negedge clk); padIn = 32'hA5C3_0F17;
    #1 v = busRdata;
    busAddr = 0; #1;
    @(negedge clk); #1 check("R4 one clock not yet", busRdata, 32'h0);
    @(negedge clk); #1 check("R4 two clocks visible", busRdata, 32'hA5C3_0F17);

    // R11 pull decode
    busWrite(20, 32'h0000_FF0F); busWrite(21, 32'h0F0F_F0F0);
    check("R11 pull up", pullUpEn, 32'h0000_F000);
    check("R11 pull down", pullDnEn, 32'h0000_0F0F);

    // R5 R6 R7 random edges
    @(negedge clk); padIn = 0;
    repeat (4) @(negedge clk);
    mRiseEn = $urandom; mFallEn = $urandom; mRiseP = 0; mFallP = 0; mPad = 0;
    busWrite(10, mRiseEn); busWrite(11, mFallEn);
    for (int it = 0; it < 30; it++) begin
      logic [31:0] nv = mPad ^ $urandom;
      @(negedge clk); padIn = nv;
      repeat (4) @(negedge clk);
      mRiseP |= nv & ~mPad & mRiseEn;
      mFallP |= ~nv & mPad & mFallEn;
      mPad = nv;
      checkPending("R5");
      begin
        int op = $urandom_range(0, 2);
        logic [31:0] m = $urandom;
        if (op == 0) begin
          busWrite(3, m); mRiseP &= ~m; mFallP &= ~m; checkPending("R6");
        end else if (op == 1) begin
          busWrite(12, m); mRiseP &= ~m; checkPending("R7");
        end else begin
          busWrite(13, m); mFallP &= ~m; checkPending("R7");
        end
      end
    end
    busRead(3, v); busWrite(3, v); mRiseP = 0; mFallP = 0;
    checkPending("R6 readback ack");

    // R8 edge and ack in same cycle on pin 5
    @(negedge clk); padIn = 0; repeat (4) @(negedge clk);
    busWrite(10, 32'h20); busWrite(11, 32'h20);
    busWrite(3, 32'hFFFF_FFFF);
    @(negedge clk); padIn[5] = 1'b1; repeat (4) @(negedge clk);
    busRead(12, v); check("R8 rise set first", v, 32'h20);
    @(negedge clk); padIn[5] = 1'b0;
    @(negedge clk);
    @(negedge clk); busAddr = 3; busWdata = 32'h20; busWe = 1'b1;
    @(negedge clk); busWe = 1'b0;
    busRead(12, v); check("R8 rise acked", v, 32'h0);
    busRead(13, v); check("R8 fall edge wins", v, 32'h20);
    check("R8 irq held", {31'b0, irqOut}, 1);
    busWrite(3, 32'hFFFF_FFFF);

    // R9 divider field
    busWrite(18, 32'hFFFF_FFFF); busRead(18, v); check("R9 field mask", v, 32'h3FFF_0000);
    busWrite(18, 32'h0007_0000); busRead(18, v); check("R9 divider 7", v, 32'h0007_0000);

    // R10 debounce on pin 2, pin 9 unfiltered
    busWrite(9, 32'h4); busWrite(10, 32'h204); busWrite(11, 0);
    repeat (20) @(negedge clk);
    busWrite(3, 32'hFFFF_FFFF);
    @(negedge clk); padIn[2] = 1'b1; padIn[9] = 1'b1;
    @(negedge clk); padIn[2] = 1'b0; padIn[9] = 1'b0;
    repeat (40) @(negedge clk);
    busRead(12, v); check("R10 glitch dropped, unfiltered kept", v, 32'h200);
    busWrite(3, 32'hFFFF_FFFF);
    @(negedge clk); padIn[2] = 1'b1;
    repeat (4) @(negedge clk);
    busRead(12, v); check("R10 not yet accepted", v, 32'h0);
    repeat (30) @(negedge clk);
    busRead(12, v); check("R10 stable accepted", v, 32'h4);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule